// File: doc/BRIEF.md
# Two-Stage Pattern Search Controller

This block drives one integer block-matching search. After a start pulse it hands candidate motion-vector offsets, one at a time, to an external cost datapath and receives one matching cost back per candidate, in the order they were issued and after a fixed delay. It keeps the candidate with the lowest cost. When the search ends it raises a one-cycle done pulse and presents the winning vector and its cost.

The search has two phases. The coarse phase visits 152 points placed on seven concentric squares around the zero vector. The inner squares are sampled densely and the outer ones sparsely, so the pattern is biased toward the centre. The fine phase then covers the 5x5 neighbourhood of the coarse winner. Any point of that neighbourhood outside the ±18 window is passed over and never issued. Each candidate holds the datapath for a 16-cycle slot, and inside a phase the slots follow one another with no gap.

Top module: `pattern_search_ctrl`

## Requirements
- R1: The coarse phase issues 152 candidates. The squares come from innermost to outermost, as (half-width, spacing) pairs: (1,1), (2,1), (4,2), (6,2), (8,2), (12,3), (18,6). On a square of half-width h with spacing s, the walk starts at corner (-h,-h). It moves along y=-h toward +x, then along x=+h toward +y, then along y=+h toward -x, then along x=-h toward -y. Each edge contributes 2h/s points, and the corner that ends an edge is the first point of the next edge.
- R2: Within a phase, consecutive candidates are issued exactly 16 cycles apart. Across the phase boundary, and after a start, they are never closer than 16 cycles.
- R3: The fine phase walks offsets (ox,oy) with oy from -2 to +2 in the outer loop and ox from -2 to +2 in the inner loop. Each offset is added to the coarse winner. A point with either component outside -18..+18 is skipped and not issued. No issued candidate ever lies outside that window.
- R4: The first cost returned after a start is always taken. After that, a cost replaces the held best only when it is strictly smaller, so on a tie the earlier candidate is kept. The best is carried across both phases, and costs are 16-bit unsigned.
- R5: Each returned cost is paired with its candidate in issue order. The fine phase begins only after every coarse cost has returned, and done is raised only after every fine cost has returned.
- R6: done is high for exactly one cycle per search. At that cycle best_dx, best_dy (two's complement) and best_cost hold the result, and they stay unchanged until the next accepted start.
- R7: A start pulse that arrives while a search is in progress has no effect on the candidate sequence or the result.
- R8: After reset, cand_valid and done are low and best_cost is all ones. After done, no candidate is issued until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| cand_valid | output | 1 | One-cycle strobe: a candidate is issued |
| cand_dx | output | 6 | Candidate horizontal offset, two's complement |
| cand_dy | output | 6 | Candidate vertical offset, two's complement |
| cost_valid | input | 1 | A cost for the oldest outstanding candidate |
| cost_in | input | 16 | Unsigned matching cost |
| done | output | 1 | One-cycle end-of-search pulse |
| best_dx | output | 6 | Winning horizontal offset |
| best_dy | output | 6 | Winning vertical offset |
| best_cost | output | 16 | Winning cost |

## Verification
The bench drives searches whose best points lie at the centre, in the open field, in two corners of the window and outside it. At the corners, a design that clipped wrongly would issue out-of-window points or drop legal ones, and the issued fine list would no longer match. Flat and all-ones cost fields test the tie rule and the first-cost rule: a design that compared with less-or-equal would report the last point, and one that only ever compared with the reset value would report the zero vector. A Manhattan cost field with many equal values does the same. Gap timing is measured against the returned costs, so a design that opened the fine phase before the coarse costs had all returned would be caught, as would a stray start that restarted the walk.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int MV_W    = 6;
    localparam int COST_W  = 16;
    localparam int N_RINGS = 7;
    localparam int LOCAL_R = 2;

    typedef logic signed [MV_W-1:0] comp_t;
    typedef logic signed [MV_W:0]   wide_t;

    typedef struct packed {
        comp_t dx;
        comp_t dy;
    } mv_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RING,
        PH_RING_DRAIN,
        PH_LOCAL,
        PH_LOCAL_DRAIN
    } phase_e;

    // half-width of coarse square k, innermost first
    function automatic int ring_radius(input logic [2:0] k);
        case (k)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 12;
            default: return 18;
        endcase
    endfunction

    // point spacing along square k
    function automatic int ring_step(input logic [2:0] k);
        case (k)
            3'd0, 3'd1:       return 1;
            3'd2, 3'd3, 3'd4: return 2;
            3'd5:             return 3;
            default:          return 6;
        endcase
    endfunction

    function automatic logic in_window(input wide_t v, input int range);
        return (int'(v) >= -range) && (int'(v) <= range);
    endfunction

endpackage

// File: rtl/psc_ring_walker.sv
module psc_ring_walker
    import psc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic advance,
    output mv_t  point,
    output logic last
);

    logic [2:0] ring;
    logic [1:0] side;
    logic [5:0] along;

    int r_i, s_i, a_i, x_i, y_i;
    logic edge_end;

    always_comb begin
        r_i = ring_radius(ring);
        s_i = ring_step(ring);
        a_i = int'(along);
        case (side)
            2'd0:    begin x_i = -r_i + a_i; y_i = -r_i;       end
            2'd1:    begin x_i =  r_i;       y_i = -r_i + a_i; end
            2'd2:    begin x_i =  r_i - a_i; y_i =  r_i;       end
            default: begin x_i = -r_i;       y_i =  r_i - a_i; end
        endcase
        point.dx = comp_t'(x_i);
        point.dy = comp_t'(y_i);
        edge_end = (a_i + s_i) == (2 * r_i);
        last     = (ring == 3'(N_RINGS - 1)) && (side == 2'd3) && edge_end;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ring  <= '0;
            side  <= '0;
            along <= '0;
        end else if (advance) begin
            if (edge_end) begin
                along <= '0;
                side  <= side + 2'd1;
                if (side == 2'd3)
                    ring <= last ? 3'd0 : ring + 3'd1;
            end else begin
                along <= along + 6'(s_i);
            end
        end
    end

endmodule

// File: rtl/psc_local_walker.sv
module psc_local_walker
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    output logic signed [2:0] ox,
    output logic signed [2:0] oy,
    output logic              last
);

    localparam logic signed [2:0] LO = -3'sd2;
    localparam logic signed [2:0] HI =  3'sd2;

    assign last = (ox == HI) && (oy == HI);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ox <= LO;
            oy <= LO;
        end else if (advance) begin
            if (ox == HI) begin
                ox <= LO;
                oy <= oy + 3'sd1;
            end else begin
                ox <= ox + 3'sd1;
            end
        end
    end

endmodule

// File: rtl/psc_order_fifo.sv
module psc_order_fifo
    import psc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  mv_t                      din,
    input  logic                     pop,
    output mv_t                      head,
    output logic                     empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    mv_t              mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/psc_best_track.sv
module psc_best_track
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic [COST_W-1:0] cost,
    input  mv_t               mv,
    output mv_t               best_mv,
    output logic [COST_W-1:0] best_cost
);

    logic first;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            best_mv   <= '0;
            best_cost <= '1;
            first     <= 1'b1;
        end else if (take) begin
            first <= 1'b0;
            if (first || (cost < best_cost)) begin
                best_mv   <= mv;
                best_cost <= cost;
            end
        end
    end

endmodule

// File: rtl/pattern_search_ctrl.sv
module pattern_search_ctrl
    import psc_pkg::*;
#(
    parameter int SLOT       = 16,
    parameter int RANGE      = 18,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              cand_valid,
    output logic [MV_W-1:0]   cand_dx,
    output logic [MV_W-1:0]   cand_dy,
    input  logic              cost_valid,
    input  logic [COST_W-1:0] cost_in,
    output logic              done,
    output logic [MV_W-1:0]   best_dx,
    output logic [MV_W-1:0]   best_dy,
    output logic [COST_W-1:0] best_cost
);

    localparam int TMR_W = (SLOT > 1) ? $clog2(SLOT) : 1;

    phase_e             phase;
    logic [TMR_W-1:0]   timer;
    mv_t                center;
    mv_t                ring_pt, local_pt, issue_mv, head_mv, best_mv;
    logic               ring_last, local_last, fifo_empty;
    logic signed [2:0]  ox, oy;
    wide_t              sum_x, sum_y;
    logic               local_ok, slot_free;
    logic               issue_ring, issue_local, skip_local, accept;

    // fine-phase point and its window test
    assign sum_x = wide_t'(center.dx) + wide_t'(ox);
    assign sum_y = wide_t'(center.dy) + wide_t'(oy);
    assign local_ok    = in_window(sum_x, RANGE) && in_window(sum_y, RANGE);
    assign local_pt.dx = comp_t'(sum_x);
    assign local_pt.dy = comp_t'(sum_y);

    assign slot_free   = (timer == '0);
    assign accept      = (phase == PH_IDLE) && start;
    assign issue_ring  = (phase == PH_RING) && slot_free;
    assign issue_local = (phase == PH_LOCAL) && slot_free && local_ok;
    assign skip_local  = (phase == PH_LOCAL) && !local_ok;

    assign cand_valid = issue_ring || issue_local;
    assign issue_mv   = issue_ring ? ring_pt : local_pt;
    assign cand_dx    = issue_mv.dx;
    assign cand_dy    = issue_mv.dy;

    assign done      = (phase == PH_LOCAL_DRAIN) && fifo_empty;
    assign best_dx   = best_mv.dx;
    assign best_dy   = best_mv.dy;

    psc_ring_walker u_ring (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .advance (issue_ring),
        .point   (ring_pt),
        .last    (ring_last)
    );

    psc_local_walker u_local (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .advance (issue_local || skip_local),
        .ox      (ox),
        .oy      (oy),
        .last    (local_last)
    );

    psc_order_fifo #(.DEPTH(FIFO_DEPTH)) u_order (
        .clk   (clk),
        .rst   (rst),
        .push  (cand_valid),
        .din   (issue_mv),
        .pop   (cost_valid),
        .head  (head_mv),
        .empty (fifo_empty)
    );

    psc_best_track u_best (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .take      (cost_valid),
        .cost      (cost_in),
        .mv        (head_mv),
        .best_mv   (best_mv),
        .best_cost (best_cost)
    );

    // slot timer: one candidate per SLOT cycles
    always_ff @(posedge clk) begin
        if (rst)
            timer <= '0;
        else if (cand_valid)
            timer <= TMR_W'(SLOT - 1);
        else if (!slot_free)
            timer <= timer - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            center <= '0;
        end else begin
            case (phase)
                PH_IDLE:
                    if (start) phase <= PH_RING;
                PH_RING:
                    if (issue_ring && ring_last) phase <= PH_RING_DRAIN;
                PH_RING_DRAIN:
                    if (fifo_empty) begin
                        center <= best_mv;
                        phase  <= PH_LOCAL;
                    end
                PH_LOCAL:
                    if ((issue_local || skip_local) && local_last)
                        phase <= PH_LOCAL_DRAIN;
                PH_LOCAL_DRAIN:
                    if (fifo_empty) phase <= PH_IDLE;
                default:
                    phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/psc_checker.sv
module psc_checker
    import psc_pkg::*;
#(
    parameter int SLOT  = 16,
    parameter int RANGE = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              cand_valid,
    input logic [MV_W-1:0]   cand_dx,
    input logic [MV_W-1:0]   cand_dy,
    input logic              cost_valid,
    input logic              done,
    input logic [MV_W-1:0]   best_dx,
    input logic [MV_W-1:0]   best_dy,
    input logic [COST_W-1:0] best_cost
);

    localparam int GAP_W = $clog2(SLOT + 1);

    logic [GAP_W-1:0] gap;
    logic             seen;
    logic [7:0]       outstanding;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap         <= '0;
            seen        <= 1'b0;
            outstanding <= '0;
        end else begin
            if (cand_valid) begin
                gap  <= '0;
                seen <= 1'b1;
            end else if (gap != GAP_W'(SLOT)) begin
                gap <= gap + 1'b1;
            end
            outstanding <= outstanding + {7'd0, cand_valid} - {7'd0, cost_valid};
        end
    end

    // R2
    slot_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (cand_valid && seen) |-> (gap >= GAP_W'(SLOT - 1)));

    // R3
    cand_window_chk: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (($signed(cand_dx) >= -RANGE) && ($signed(cand_dx) <= RANGE) &&
                        ($signed(cand_dy) >= -RANGE) && ($signed(cand_dy) <= RANGE)));

    // R5
    all_returned_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (outstanding == 8'd0));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(best_dx) && $stable(best_dy) && $stable(best_cost)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !cand_valid);

endmodule

bind pattern_search_ctrl psc_checker #(.SLOT(SLOT), .RANGE(RANGE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cand_valid (cand_valid),
    .cand_dx    (cand_dx),
    .cand_dy    (cand_dy),
    .cost_valid (cost_valid),
    .done       (done),
    .best_dx    (best_dx),
    .best_dy    (best_dy),
    .best_cost  (best_cost)
);

// File: tb/sim_pattern_search_ctrl.sv
`timescale 1ns/1ps
module sim_pattern_search_ctrl;

    localparam int LAT   = 21;
    localparam int SLOTC = 16;
    localparam int WIN   = 18;
    localparam int N1    = 152;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cand_valid;
    logic [5:0]  cand_dx, cand_dy;
    logic        cost_valid = 1'b0;
    logic [15:0] cost_in = '0;
    logic        done;
    logic [5:0]  best_dx, best_dy;
    logic [15:0] best_cost;

    pattern_search_ctrl u0 (
        .clk(clk), .rst(rst), .start(start),
        .cand_valid(cand_valid), .cand_dx(cand_dx), .cand_dy(cand_dy),
        .cost_valid(cost_valid), .cost_in(cost_in),
        .done(done), .best_dx(best_dx), .best_dy(best_dy), .best_cost(best_cost)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int mode = 0, tx = 0, ty = 0;
    int n_iss = 0, n_ret = 0;
    int iss_dx [400];
    int iss_dy [400];
    int iss_t  [400];
    int done_cnt = 0, done_t = 0, cap_dx = 0, cap_dy = 0, cap_cost = 0;
    int exp_dx [200];
    int exp_dy [200];
    int n_exp = 0, exp_bx = 0, exp_by = 0, exp_bc = 0;
    bit finished = 0;

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int cost_of(input int x, input int y);
        case (mode)
            0:       return 3 * iabs(x - tx) + 5 * iabs(y - ty) + 100;
            1:       return 500;
            2:       return 65535;
            default: return iabs(x - tx) + iabs(y - ty);
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // cost datapath model and output monitor
    initial forever begin
        @(negedge clk);
        if (cand_valid) begin
            iss_dx[n_iss] = $signed(cand_dx);
            iss_dy[n_iss] = $signed(cand_dy);
            iss_t[n_iss]  = cyc;
            if (n_iss < 399) n_iss++;
        end
        if (done) begin
            done_cnt++;
            done_t   = cyc;
            cap_dx   = $signed(best_dx);
            cap_dy   = $signed(best_dy);
            cap_cost = best_cost;
        end
        if (n_ret < n_iss && iss_t[n_ret] + LAT == cyc) begin
            cost_valid = 1'b1;
            cost_in    = 16'(cost_of(iss_dx[n_ret], iss_dy[n_ret]));
            n_ret++;
        end else begin
            cost_valid = 1'b0;
        end
    end

    task automatic build_expected();
        int rr [7] = '{1, 2, 4, 6, 8, 12, 18};
        int ss [7] = '{1, 1, 2, 2, 2, 3, 6};
        int bc, bx, by, c;
        n_exp = 0;
        for (int k = 0; k < 7; k++) begin
            int per = 2 * rr[k] / ss[k];
            for (int i = 0; i < 4 * per; i++) begin
                int sd = i / per;
                int a  = (i % per) * ss[k];
                int h  = rr[k];
                case (sd)
                    0: begin exp_dx[n_exp] = -h + a; exp_dy[n_exp] = -h;     end
                    1: begin exp_dx[n_exp] =  h;     exp_dy[n_exp] = -h + a; end
                    2: begin exp_dx[n_exp] =  h - a; exp_dy[n_exp] =  h;     end
                    default: begin exp_dx[n_exp] = -h; exp_dy[n_exp] = h - a; end
                endcase
                n_exp++;
            end
        end
        bx = exp_dx[0]; by = exp_dy[0]; bc = cost_of(bx, by);
        for (int i = 1; i < n_exp; i++) begin
            c = cost_of(exp_dx[i], exp_dy[i]);
            if (c < bc) begin bc = c; bx = exp_dx[i]; by = exp_dy[i]; end
        end
        begin
            int cx = bx, cy = by;
            for (int oy = -2; oy <= 2; oy++)
                for (int ox = -2; ox <= 2; ox++) begin
                    int x = cx + ox, y = cy + oy;
                    if (iabs(x) <= WIN && iabs(y) <= WIN) begin
                        exp_dx[n_exp] = x; exp_dy[n_exp] = y; n_exp++;
                        c = cost_of(x, y);
                        if (c < bc) begin bc = c; bx = x; by = y; end
                    end
                end
        end
        exp_bx = bx; exp_by = by; exp_bc = bc;
    endtask

    task automatic run_search(input int m, input int x, input int y, input bit restart_pulse);
        int prev_done, guard, mis1, mis2, gapbad, first_bad;
        mode = m; tx = x; ty = y;
        build_expected();
        @(negedge clk);
        n_iss = 0; n_ret = 0;
        prev_done = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart_pulse) begin
            repeat (600) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done_cnt == prev_done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 20000, "R6 done reached", guard, 0);
        repeat (10) @(negedge clk);

        check(n_iss == n_exp, "R3 candidate count", n_iss, n_exp);
        mis1 = 0; mis2 = 0; first_bad = -1;
        for (int i = 0; i < n_exp && i < n_iss; i++)
            if (iss_dx[i] != exp_dx[i] || iss_dy[i] != exp_dy[i]) begin
                if (i < N1) mis1++; else mis2++;
                if (first_bad < 0) first_bad = i;
            end
        check(mis1 == 0, "R1 coarse sequence mismatches", mis1, 0);
        check(mis2 == 0, "R3 fine sequence mismatches", mis2, 0);
        if (first_bad >= 0)
            $display("  first mismatch at %0d: got (%0d,%0d) want (%0d,%0d)", first_bad,
                     iss_dx[first_bad], iss_dy[first_bad], exp_dx[first_bad], exp_dy[first_bad]);
        gapbad = 0;
        for (int i = 1; i < n_iss; i++)
            if (i != N1 && iss_t[i] - iss_t[i-1] != SLOTC) gapbad++;
        check(gapbad == 0, "R2 in-phase slot spacing errors", gapbad, 0);
        if (n_iss > N1)
            check(iss_t[N1] > iss_t[N1-1] + LAT, "R5 fine phase after last coarse cost",
                  iss_t[N1], iss_t[N1-1] + LAT + 1);
        check(n_iss > 0 && done_t > iss_t[n_iss-1] + LAT, "R5 done after last fine cost",
              done_t, iss_t[(n_iss > 0) ? n_iss-1 : 0] + LAT + 1);
        check(cap_dx == exp_bx, "R4 best_dx", cap_dx, exp_bx);
        check(cap_dy == exp_by, "R4 best_dy", cap_dy, exp_by);
        check(cap_cost == exp_bc, "R4 best_cost", cap_cost, exp_bc);
        check(done_cnt - prev_done == 1, "R6 done pulse width", done_cnt - prev_done, 1);
        check($signed(best_dx) == cap_dx && best_cost == 16'(cap_cost), "R6 result held",
              $signed(best_dx), cap_dx);
        check(iss_t[n_iss-1] < done_t, "R8 no issue after done", iss_t[n_iss-1], done_t);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(cand_valid == 1'b0, "R8 reset cand_valid", cand_valid, 0);
        check(done == 1'b0, "R8 reset done", done, 0);
        check(best_cost == 16'hFFFF, "R8 reset best_cost", best_cost, 65535);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(cand_valid == 1'b0, "R8 idle without start", cand_valid, 0);

        run_search(0,   0,   0, 1'b0);
        run_search(0,   7,  -5, 1'b1);  // R7 stray start mid-search
        run_search(0,  18,  18, 1'b0);
        run_search(0, -19, -17, 1'b0);
        run_search(1,   0,   0, 1'b0);  // flat field: R4 tie keeps first
        run_search(2,   0,   0, 1'b0);  // all-ones costs: R4 first cost taken
        run_search(3,   5,   3, 1'b0);
        run_search(0, -18,  18, 1'b0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule